// File: doc/BRIEF.md
# UART receiver status flag unit

This unit sits behind a UART receive shift engine and turns each finished character into bus-visible state. When the shift engine signals that a character is complete, the unit stores the byte in a holding register and raises a receive-full flag. If the previous byte has not been read yet, it raises an overrun flag and drops the new byte. A noise indication from the shift engine raises a noise flag. An error interrupt line combines the overrun and noise flags, each gated by its own enable bit in a control register.

Software clears the error flags with a two-step sequence: read the status register, then read the data register. At every status read the unit takes a snapshot of the error flags. The following data read clears only the flags present in that snapshot, so an overrun that occurs between the two reads survives and is seen by the next sequence. The character input is a valid/ready stream whose ready is always high: the unit never applies back-pressure. When software falls behind, the stream does not stall. Bytes that find the holding register full are dropped and flagged as an overrun.

Top module: `rxs_status_unit`

## Requirements
- R1: After reset the status register reads 0x00, the control register reads 0x00, `err_irq` is low and `rx_ready` is high.
- R2: A character accepted while receive-full is clear is stored in the holding register, and receive-full becomes set. `rx_ready` is always 1.
- R3: A character that arrives while receive-full is set, with no data read in the same cycle, sets the overrun flag. That byte is dropped and the held byte is unchanged.
- R4: The bus has three registers: status at address 0, data at address 1 and control at address 2. In the status register, receive-full is bit 5, overrun is bit 3 and noise is bit 2, and every other bit reads 0. A read strobe in cycle t yields `rd_valid` and `rd_data` in cycle t+1, holding the value the register had before that cycle's update.
- R5: An error flag is cleared only by a data read that follows a status read which saw that flag set. A flag set between the two reads stays set. After such a late overrun, the next data read returns the byte that arrived after the lost one.
- R6: A data read with no status snapshot pending returns the held byte and clears receive-full, but clears no error flag.
- R7: A character reported with noise sets the noise flag. A status read followed by a data read clears it.
- R8: `err_irq` is high exactly when (overrun and control bit 3) or (noise and control bit 2). The control register reads back bits 3 and 2 only. Writes to addresses other than 2 have no effect.
- R9: A data read and a character arrival in the same cycle return the old byte, load the new byte and leave receive-full set without an overrun. A flag being set wins over a clear in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Character-complete strobe from the shift engine |
| rx_ready | output | 1 | Always 1; the unit accepts every character |
| rx_byte | input | DATA_W | Received character |
| rx_noise | input | 1 | Noise seen while receiving this character |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after `bus_rd` |
| rd_data | output | DATA_W | Read data |
| err_irq | output | 1 | Error interrupt request |

## Verification
The bench applies four patterns to the clearing logic:
- A prompt status/data sequence per byte, which separates correct clearing from flags that stick.
- Two back-to-back characters, which separate dropping the new byte from overwriting the held one.
- An overrun landing between the status and data reads, which separates the snapshot rule from a blanket clear. It also shows that the byte after the lost one is the next one returned.
- A bare data read on a noisy byte, which shows that a data read alone clears only receive-full.

A read that coincides with a character arrival checks the set-over-clear priority. The interrupt is checked with each enable on its own, so a swapped enable bit is detected.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int unsigned FULL_POS = 5;
  localparam int unsigned OVR_POS  = 3;
  localparam int unsigned NSE_POS  = 2;

  localparam int unsigned ADR_STAT = 0;
  localparam int unsigned ADR_DATA = 1;
  localparam int unsigned ADR_CTRL = 2;

  // error flag indices, also the order of the flag vector
  localparam int unsigned ERR_OVR = 0;
  localparam int unsigned ERR_NSE = 1;
  localparam int unsigned N_ERR   = 2;
endpackage

// File: rtl/rxs_decode.sv
module rxs_decode #(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              stat_rd,
  output logic              data_rd,
  output logic              ctrl_rd,
  output logic              ctrl_wr
);
  import rxs_pkg::*;

  logic hit_stat, hit_data, hit_ctrl;

  always_comb begin
    hit_stat = (bus_addr == ADDR_W'(ADR_STAT));
    hit_data = (bus_addr == ADDR_W'(ADR_DATA));
    hit_ctrl = (bus_addr == ADDR_W'(ADR_CTRL));
    stat_rd  = bus_rd & hit_stat;
    data_rd  = bus_rd & hit_data;
    ctrl_rd  = bus_rd & hit_ctrl;
    ctrl_wr  = bus_wr & hit_ctrl;
  end
endmodule

// File: rtl/rxs_hold.sv
module rxs_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              data_rd,
  output logic [DATA_W-1:0] hold_byte,
  output logic              full,
  output logic              ovr_evt
);
  logic take;

  // a same-cycle data read frees the register for the incoming byte
  always_comb begin
    take    = rx_valid & (~full | data_rd);
    ovr_evt = rx_valid & full & ~data_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_byte <= '0;
      full      <= 1'b0;
    end else begin
      if (take) hold_byte <= rx_byte;
      if (rx_valid)     full <= 1'b1;
      else if (data_rd) full <= 1'b0;
    end
  end

  p_full_after_char_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> full);

  p_drop_keeps_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && full && !data_rd) |=> $stable(hold_byte));

  p_read_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !rx_valid) |=> !full);
endmodule

// File: rtl/rxs_errs.sv
module rxs_errs #(
  parameter int unsigned N_FLAG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_FLAG-1:0] set_vec,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [N_FLAG-1:0] flags
);
  logic [N_FLAG-1:0] snap;

  for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags[g] <= 1'b0;
        snap[g]  <= 1'b0;
      end else begin
        // set wins over a clear in the same cycle
        if (set_vec[g])                flags[g] <= 1'b1;
        else if (data_rd && snap[g])   flags[g] <= 1'b0;
        if (stat_rd)      snap[g] <= flags[g];
        else if (data_rd) snap[g] <= 1'b0;
      end
    end

    p_clear_needs_snap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[g] && !(data_rd && snap[g])) |=> flags[g]);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[g] |=> flags[g]);
  end
endmodule

// File: rtl/rxs_regs.sv
module rxs_regs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              ctrl_rd,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              full,
  input  logic              ovr,
  input  logic              nse,
  input  logic [DATA_W-1:0] hold_byte,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              err_irq
);
  import rxs_pkg::*;

  localparam logic [DATA_W-1:0] CTRL_MASK =
    (DATA_W'(1) << OVR_POS) | (DATA_W'(1) << NSE_POS);

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] stat_w;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    stat_w           = '0;
    stat_w[FULL_POS] = full;
    stat_w[OVR_POS]  = ovr;
    stat_w[NSE_POS]  = nse;
    if (stat_rd)      rd_mux = stat_w;
    else if (data_rd) rd_mux = hold_byte;
    else if (ctrl_rd) rd_mux = ctrl_q;
    else              rd_mux = '0;
    err_irq = (ovr & ctrl_q[OVR_POS]) | (nse & ctrl_q[NSE_POS]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata & CTRL_MASK;
      rd_valid <= stat_rd | data_rd | ctrl_rd;
      rd_data  <= rd_mux;
    end
  end

  p_irq_has_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (ovr || nse));

  p_read_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd || data_rd || ctrl_rd) |=> rd_valid);
endmodule

// File: rtl/rxs_status_unit.sv
module rxs_status_unit #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_noise,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              err_irq
);
  import rxs_pkg::*;

  logic              stat_rd, data_rd, ctrl_rd, ctrl_wr;
  logic [DATA_W-1:0] hold_byte;
  logic              full, ovr_evt;
  logic [N_ERR-1:0]  err_set, err_flags;

  assign rx_ready = 1'b1;

  always_comb begin
    err_set          = '0;
    err_set[ERR_OVR] = ovr_evt;
    err_set[ERR_NSE] = rx_valid & rx_noise;
  end

  rxs_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .stat_rd(stat_rd), .data_rd(data_rd), .ctrl_rd(ctrl_rd), .ctrl_wr(ctrl_wr)
  );

  rxs_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .data_rd(data_rd), .hold_byte(hold_byte), .full(full), .ovr_evt(ovr_evt)
  );

  rxs_errs #(.N_FLAG(N_ERR)) u_errs (
    .clk(clk), .rst_n(rst_n), .set_vec(err_set),
    .stat_rd(stat_rd), .data_rd(data_rd), .flags(err_flags)
  );

  rxs_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .data_rd(data_rd),
    .ctrl_rd(ctrl_rd), .ctrl_wr(ctrl_wr), .bus_wdata(bus_wdata),
    .full(full), .ovr(err_flags[ERR_OVR]), .nse(err_flags[ERR_NSE]),
    .hold_byte(hold_byte), .rd_valid(rd_valid), .rd_data(rd_data),
    .err_irq(err_irq)
  );

  p_ready_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready);
endmodule

// File: tb/rxs_status_unit_bench.sv
module rxs_status_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic [7:0] rx_byte = '0;
  logic       rx_noise = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       err_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  rxs_status_unit u_rxs_status_unit (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_byte(rx_byte), .rx_noise(rx_noise), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .err_irq(err_irq)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: pops the scoreboard as read results appear
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (q_exp.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R4: unexpected rd_valid, got %h expected none", rd_data);
      end else begin
        chk(rd_data, q_exp.pop_front(), q_tag.pop_front());
      end
    end
  end

  // all driver tasks start and end at a falling edge
  task automatic send(input logic [7:0] b, input logic nz);
    rx_valid = 1'b1; rx_byte = b; rx_noise = nz;
    @(negedge clk);
    rx_valid = 1'b0; rx_noise = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({7'd0, err_irq}, 8'h00, "R1 irq after reset");
    chk({7'd0, rx_ready}, 8'h01, "R1 ready after reset");
    rd(2'd0, 8'h00, "R1 status after reset");
    rd(2'd2, 8'h00, "R1 control after reset");

    // R2 normal reception and clearing
    send(8'h41, 1'b0);
    rd(2'd0, 8'h20, "R2 full set");
    rd(2'd1, 8'h41, "R2 byte held");
    rd(2'd0, 8'h00, "R2 full cleared");

    // R3 back-to-back overrun, prompt clearing
    send(8'h11, 1'b0);
    send(8'h22, 1'b0);
    rd(2'd0, 8'h28, "R3 overrun flagged");
    rd(2'd1, 8'h11, "R3 old byte kept");
    rd(2'd0, 8'h00, "R4 overrun cleared by sequence");

    // R5 overrun arriving between status and data reads
    send(8'h31, 1'b0);
    rd(2'd0, 8'h20, "R5 status before late overrun");
    send(8'h32, 1'b0);
    rd(2'd1, 8'h31, "R5 data read returns first byte");
    rd(2'd0, 8'h08, "R5 late overrun survives");
    send(8'h33, 1'b0);
    rd(2'd0, 8'h28, "R5 status sees overrun");
    rd(2'd1, 8'h33, "R5 byte after lost one");
    rd(2'd0, 8'h00, "R5 cleared by next sequence");

    // R6 and R7 bare data read on a noisy byte
    send(8'h44, 1'b1);
    rd(2'd1, 8'h44, "R6 bare data read");
    rd(2'd0, 8'h04, "R6 noise kept by bare read");
    rd(2'd1, 8'h44, "R7 data read after status");
    rd(2'd0, 8'h00, "R7 noise cleared");

    // R8 interrupt enables
    wr(2'd0, 8'hFF);
    rd(2'd0, 8'h00, "R8 write to status ignored");
    wr(2'd2, 8'h04);
    rd(2'd2, 8'h04, "R8 control readback");
    send(8'h01, 1'b1);
    chk({7'd0, err_irq}, 8'h01, "R8 irq on noise");
    rd(2'd0, 8'h24, "R8 status noise");
    rd(2'd1, 8'h01, "R8 data");
    chk({7'd0, err_irq}, 8'h00, "R8 irq dropped after clear");
    wr(2'd2, 8'h08);
    send(8'h02, 1'b1);
    chk({7'd0, err_irq}, 8'h00, "R8 noise masked");
    send(8'h03, 1'b0);
    chk({7'd0, err_irq}, 8'h01, "R8 irq on overrun");
    rd(2'd0, 8'h2C, "R8 status all flags");
    rd(2'd1, 8'h02, "R8 data kept");
    chk({7'd0, err_irq}, 8'h00, "R8 irq cleared");
    wr(2'd2, 8'hFF);
    rd(2'd2, 8'h0C, "R8 unused control bits");
    wr(2'd2, 8'h00);

    // R9 data read coinciding with a noisy arrival
    send(8'h55, 1'b1);
    rd(2'd0, 8'h24, "R9 setup status");
    rx_valid = 1'b1; rx_byte = 8'h66; rx_noise = 1'b1;
    rd(2'd1, 8'h55, "R9 old byte on same-cycle read");
    rx_valid = 1'b0; rx_noise = 1'b0;
    rd(2'd0, 8'h24, "R9 full and noise kept, no overrun");
    rd(2'd1, 8'h66, "R9 new byte loaded");
    rd(2'd0, 8'h00, "R9 final clear");

    repeat (3) @(negedge clk);
    chk(8'(q_exp.size()), 8'h00, "R4 all reads answered");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule